// File: doc/BRIEF.md
# Accumulator and Register Transfer Datapath

This block is the execution core of a very small accumulator machine. It holds an accumulator, one general-purpose register and a registered output port, and it carries out one of ten fixed register-transfer operations per clock cycle. Each operation is selected by a 4-bit code. The operations load from the input bus, copy between the two registers, store to the output port, add, OR, AND, or complement the accumulator. There is no instruction memory, no program counter and no flag. An outside sequencer presents one code and one data word per cycle.

An operation is accepted on a rising clock edge when `instr_valid` is high. The block has no `ready` signal and never applies back-pressure. Every cycle with `instr_valid` high is consumed, and its effect is visible after that same edge. The output port is a register that changes only under the two store codes. The internal state is observed by storing a register to the output port. The data width is the parameter `W`, which defaults to 8.

Top module: `acc_datapath`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge clears the accumulator, the register and `out_data` to zero.
- R2: Code 1 and code 6 each load the accumulator with `in_data`.
- R3: Code 5 loads the register with `in_data`, and code 2 copies the accumulator into the register.
- R4: Code 3 writes the register to `out_data`, and code 4 writes the accumulator to `out_data`. The new value appears after the accepting edge.
- R5: Code 7 replaces the accumulator with the accumulator plus the register, modulo 2^W, and keeps no carry.
- R6: Code 8 replaces the accumulator with its bitwise OR with the register. Code 9 does the same with bitwise AND.
- R7: Code 10 replaces the accumulator with its bitwise complement.
- R8: The register keeps its value under every code other than 2 and 5.
- R9: `out_data` keeps its value under every code other than 3 and 4.
- R10: Code 0 and codes 11 to 15 change neither the accumulator, the register nor `out_data`.
- R11: While `instr_valid` is low, no state changes, whatever the code and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Operation strobe; accepted every cycle it is high |
| instr_code | input | 4 | Operation code, 1 to 10 meaningful |
| in_data | input | W | Input bus read by the load codes |
| out_data | output | W | Registered output port |

## Verification
The main function is driven with operand pairs chosen to separate the operations. Sums that overflow 2^W show whether the carry is dropped. A value and its complement show the inversion of every bit. Overlapping bit patterns give an OR, an AND and a sum that all differ from one another. A long run of non-register codes after a distinctive register load shows whether any of them disturbs the register. Reserved codes and deasserted strobes are applied with `in_data` set to all ones, while the accumulator differs from the output port. A stray load or store would therefore show on the output port in the next store.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] C_LDI = 4'd1;
  localparam logic [CODE_W-1:0] C_A2R = 4'd2;
  localparam logic [CODE_W-1:0] C_STR = 4'd3;
  localparam logic [CODE_W-1:0] C_STA = 4'd4;
  localparam logic [CODE_W-1:0] C_LDR = 4'd5;
  localparam logic [CODE_W-1:0] C_LDA = 4'd6;
  localparam logic [CODE_W-1:0] C_ADD = 4'd7;
  localparam logic [CODE_W-1:0] C_IOR = 4'd8;
  localparam logic [CODE_W-1:0] C_IAND = 4'd9;
  localparam logic [CODE_W-1:0] C_INV = 4'd10;

  typedef enum logic [1:0] {ASRC_KEEP, ASRC_IN, ASRC_ALU} a_src_e;
  typedef enum logic [1:0] {RSRC_KEEP, RSRC_IN, RSRC_ACC} r_src_e;
  typedef enum logic [1:0] {OSRC_KEEP, OSRC_REG, OSRC_ACC} o_src_e;
  typedef enum logic [1:0] {ALU_ADD, ALU_OR, ALU_AND, ALU_INV} alu_op_e;

  typedef struct packed {
    a_src_e  a_src;
    alu_op_e alu_op;
    r_src_e  r_src;
    o_src_e  o_src;
  } ctrl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_dp_pkg::*;
(
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  output ctrl_t             ctrl
);
  always_comb begin
    ctrl = '{a_src: ASRC_KEEP, alu_op: ALU_ADD, r_src: RSRC_KEEP, o_src: OSRC_KEEP};
    if (valid) begin
      case (code)
        C_LDI, C_LDA: ctrl.a_src = ASRC_IN;
        C_A2R:        ctrl.r_src = RSRC_ACC;
        C_LDR:        ctrl.r_src = RSRC_IN;
        C_STR:        ctrl.o_src = OSRC_REG;
        C_STA:        ctrl.o_src = OSRC_ACC;
        C_ADD:        begin ctrl.a_src = ASRC_ALU; ctrl.alu_op = ALU_ADD; end
        C_IOR:        begin ctrl.a_src = ASRC_ALU; ctrl.alu_op = ALU_OR;  end
        C_IAND:       begin ctrl.a_src = ASRC_ALU; ctrl.alu_op = ALU_AND; end
        C_INV:        begin ctrl.a_src = ASRC_ALU; ctrl.alu_op = ALU_INV; end
        default:      ctrl.a_src = ASRC_KEEP;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] reg_v,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  logic [W-1:0] sum;
  logic [W-1:0] bit_or;
  logic [W-1:0] bit_and;
  logic [W-1:0] bit_inv;

  assign sum = acc + reg_v;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_or[i]  = acc[i] | reg_v[i];
    assign bit_and[i] = acc[i] & reg_v[i];
    assign bit_inv[i] = ~acc[i];
  end

  always_comb begin
    case (op)
      ALU_ADD: y = sum;
      ALU_OR:  y = bit_or;
      ALU_AND: y = bit_and;
      default: y = bit_inv;
    endcase
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [CODE_W-1:0] instr_code,
  input  logic [W-1:0]      in_data,
  output logic [W-1:0]      out_data
);
  ctrl_t        ctrl;
  logic [W-1:0] a_q;
  logic [W-1:0] r_q;
  logic [W-1:0] alu_y;

  acc_decode u_dec (
    .valid (instr_valid),
    .code  (instr_code),
    .ctrl  (ctrl)
  );

  acc_alu #(.W(W)) u_alu (
    .acc   (a_q),
    .reg_v (r_q),
    .op    (ctrl.alu_op),
    .y     (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= '0;
      r_q      <= '0;
      out_data <= '0;
    end else begin
      case (ctrl.a_src)
        ASRC_IN:  a_q <= in_data;
        ASRC_ALU: a_q <= alu_y;
        default:  a_q <= a_q;
      endcase
      case (ctrl.r_src)
        RSRC_IN:  r_q <= in_data;
        RSRC_ACC: r_q <= a_q;
        default:  r_q <= r_q;
      endcase
      case (ctrl.o_src)
        OSRC_REG: out_data <= r_q;
        OSRC_ACC: out_data <= a_q;
        default:  out_data <= out_data;
      endcase
    end
  end
endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         instr_valid,
  input logic [3:0]   instr_code,
  input logic [W-1:0] in_data,
  input logic [W-1:0] out_data,
  input logic [W-1:0] a_q,
  input logic [W-1:0] r_q
);
  // R2
  lda_in_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_code == 4'd6 |=> a_q == $past(in_data));
  // R3
  ldr_in_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_code == 4'd5 |=> r_q == $past(in_data));
  // R4
  store_reg_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_code == 4'd3 |=> out_data == $past(r_q));
  // R5
  add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_code == 4'd7 |=> a_q == W'($past(a_q) + $past(r_q)));
  // R7
  invert_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_code == 4'd10 |=> a_q == ~$past(a_q));
  // R8
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(instr_valid && (instr_code == 4'd2 || instr_code == 4'd5)) |=> $stable(r_q));
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(instr_valid && (instr_code == 4'd3 || instr_code == 4'd4)) |=> $stable(out_data));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(a_q) && $stable(r_q) && $stable(out_data));
endmodule

bind acc_datapath acc_datapath_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr_code  (instr_code),
  .in_data     (in_data),
  .out_data    (out_data),
  .a_q         (a_q),
  .r_q         (r_q)
);

// File: tb/tb_acc_datapath.sv
`timescale 1ns/1ps
module tb_acc_datapath;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         instr_valid = 1'b0;
  logic [3:0]   instr_code = 4'd0;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] m_a = '0, m_r = '0, m_o = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  acc_datapath #(.W(W)) dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid),
    .instr_code(instr_code), .in_data(in_data), .out_data(out_data)
  );

  // Monitor: compares the port against the queued expectation
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (out_data !== e) begin
        errors++;
        $display("FAIL %s: out_data=%h expected=%h", t, out_data, e);
      end
    end
  end

  // Driver: applies one operation and queues the expected port value
  task automatic issue(input bit v, input logic [3:0] c, input logic [W-1:0] d, input string t);
    @(negedge clk);
    instr_valid = v;
    instr_code  = c;
    in_data     = d;
    @(posedge clk);
    if (v) begin
      logic [W-1:0] na, nr, no;
      na = m_a; nr = m_r; no = m_o;
      case (c)
        4'd1, 4'd6: na = d;
        4'd2: nr = m_a;
        4'd3: no = m_r;
        4'd4: no = m_a;
        4'd5: nr = d;
        4'd7: na = m_a + m_r;
        4'd8: na = m_a | m_r;
        4'd9: na = m_a & m_r;
        4'd10: na = ~m_a;
        default: ;
      endcase
      m_a = na; m_r = nr; m_o = no;
    end
    exp_q.push_back(m_o);
    tag_q.push_back(t);
  endtask

  task automatic show_a(input string t); issue(1'b1, 4'd4, 8'h00, t); endtask
  task automatic show_r(input string t); issue(1'b1, 4'd3, 8'h00, t); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (out_data !== '0) begin
      errors++;
      $display("FAIL R1: out_data=%h expected=00", out_data);
    end
    show_a("R1 acc cleared");
    show_r("R1 reg cleared");

    issue(1'b1, 4'd1, 8'h5A, "R9 load leaves out");
    show_a("R2 code 1");
    issue(1'b1, 4'd6, 8'h33, "R9 load leaves out");
    show_a("R2 code 6");
    issue(1'b1, 4'd5, 8'hC4, "R9");
    show_r("R3 code 5");
    issue(1'b1, 4'd2, 8'hFF, "R9");
    show_r("R3 code 2");
    show_a("R4 code 4");

    issue(1'b1, 4'd5, 8'hF0, "R9");
    issue(1'b1, 4'd6, 8'h20, "R9");
    issue(1'b1, 4'd7, 8'h00, "R9");
    show_a("R5 wrap F0+20");
    issue(1'b1, 4'd6, 8'hFF, "R9");
    issue(1'b1, 4'd5, 8'h01, "R9");
    issue(1'b1, 4'd7, 8'h00, "R9");
    show_a("R5 wrap FF+01");

    issue(1'b1, 4'd5, 8'hF0, "R9");
    issue(1'b1, 4'd6, 8'h3C, "R9");
    issue(1'b1, 4'd8, 8'h00, "R9");
    show_a("R6 OR");
    issue(1'b1, 4'd6, 8'h3C, "R9");
    issue(1'b1, 4'd9, 8'h00, "R9");
    show_a("R6 AND");
    issue(1'b1, 4'd6, 8'h3C, "R9");
    issue(1'b1, 4'd10, 8'h00, "R9");
    show_a("R7 complement");
    issue(1'b1, 4'd10, 8'h00, "R9");
    show_a("R7 double complement");

    // R8: register survives every other code
    issue(1'b1, 4'd5, 8'hA5, "R9");
    issue(1'b1, 4'd1, 8'h11, "R8");
    issue(1'b1, 4'd6, 8'h22, "R8");
    issue(1'b1, 4'd7, 8'h00, "R8");
    issue(1'b1, 4'd8, 8'h00, "R8");
    issue(1'b1, 4'd9, 8'h00, "R8");
    issue(1'b1, 4'd10, 8'h00, "R8");
    show_a("R8 acc path");
    show_r("R8 reg kept");

    // R10: reserved codes with all-ones data; acc differs from out
    issue(1'b1, 4'd6, 8'h4B, "R9");
    issue(1'b1, 4'd5, 8'h96, "R9");
    issue(1'b1, 4'd0, 8'hFF, "R10 code 0");
    for (int k = 11; k < 16; k++) issue(1'b1, 4'(k), 8'hFF, "R10 reserved");
    show_a("R10 acc kept");
    show_r("R10 reg kept");

    // R11: strobe low, including store and load codes
    issue(1'b1, 4'd6, 8'h69, "R9");
    issue(1'b0, 4'd4, 8'hFF, "R11 store ignored");
    issue(1'b0, 4'd6, 8'hFF, "R11");
    issue(1'b0, 4'd5, 8'hFF, "R11");
    issue(1'b0, 4'd10, 8'hFF, "R11");
    show_a("R11 acc kept");
    show_r("R11 reg kept");

    // R1 again mid-run
    @(negedge clk);
    instr_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_a = '0; m_r = '0; m_o = '0;
    checks++;
    if (out_data !== '0) begin
      errors++;
      $display("FAIL R1: out_data=%h expected=00", out_data);
    end
    show_a("R1 acc cleared again");
    show_r("R1 reg cleared again");

    @(negedge clk);
    instr_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule